// File: doc/BRIEF.md
# Operand Fetch Unit with Eight Addressing Modes

This block sits between instruction decode and the accumulator datapath of a simple accumulator machine. When decode raises a start request, the unit takes a 3-bit mode code and a 12-bit address/operand field. It works out the effective address and returns the operand the instruction names, along with a single-cycle completion pulse. The operand can be a constant, the contents of a register, or a word in memory. For a memory word, the address can come directly from the field, from a register, from the field plus the index register, from the base register plus the field, from the stack pointer, or from a pointer word held in memory.

The unit is a small multi-cycle controller in front of a synchronous single-port memory, where read data returns one cycle after the address is presented. Modes that need no memory finish in two cycles. Modes that need one read finish in three. Indirect mode uses the first read's data as the address of a second read and finishes in four. A start request that arrives while the unit is busy is dropped.

Top module: `opf_unit`

## Requirements
- R1: After reset, done_o, busy_o and mem_req_o are 0, and operand_o and ea_o are 0.
- R2: Mode 0 (immediate): operand_o and ea_o both equal the field, and no memory request is issued.
- R3: Mode 1 (direct): one read at address field; ea_o = field, and operand_o = the word read.
- R4: Mode 2 (register): register index = field[2:0], driven on reg_sel_o. operand_o = reg_rdata_i, ea_o = the zero-extended index, and no memory request is issued.
- R5: Mode 3 (indirect): a first read at field returns a pointer. ea_o = that pointer. A second read at the pointer returns operand_o.
- R6: Mode 4 (register indirect): the register selected by field[2:0] holds ea_o, and one read there returns operand_o.
- R7: Mode 5 (indexed): ea_o = (field + idx_i) mod 4096, and one read there returns operand_o.
- R8: Mode 6 (based): ea_o = (base_i + field) mod 4096, and one read there returns operand_o.
- R9: Mode 7 (stack): ea_o = sp_i, and one read there returns operand_o. The field is not used.
- R10: done_o is high for exactly one cycle. It rises 2 cycles after the start sampling edge for modes 0 and 2, 4 cycles for mode 3, and 3 cycles for the others.
- R11: A start request while busy_o is high is ignored: no extra done pulse, and the outputs keep the result of the accepted request.
- R12: mem_req_o is asserted only while busy, once per read. A mode issues 0, 1 or 2 reads, and read data is taken one cycle after its request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Fetch request, sampled while idle |
| mode_i | input | 3 | Addressing mode code |
| field_i | input | 12 | Address/operand field of the instruction |
| reg_sel_o | output | 3 | Register file read index |
| reg_rdata_i | input | 12 | Register file read data (combinational) |
| idx_i | input | 12 | Index register value |
| base_i | input | 12 | Base register value |
| sp_i | input | 12 | Stack pointer value |
| mem_req_o | output | 1 | Memory read request |
| mem_addr_o | output | 12 | Memory read address |
| mem_rdata_i | input | 12 | Memory read data, valid one cycle after the request |
| operand_o | output | 12 | Fetched operand, held until the next fetch |
| ea_o | output | 12 | Effective address, held until the next fetch |
| done_o | output | 1 | Completion pulse |
| busy_o | output | 1 | Fetch in progress |

## Verification
The bench builds the unit with its defaults: a 12-bit word and eight registers. This makes the 4096-word address wrap reachable with field 0xFFF plus index 0x040, and with base 0x300 plus field 0xD10. The memory model returns an affine function of the address, so every mode, including the chained pointer read, produces a distinct expected value. The three latency classes and the read count per mode are measured at the ports.

// File: rtl/opf_pkg.sv
package opf_pkg;
  typedef enum logic [2:0] {
    M_IMM  = 3'd0,
    M_DIR  = 3'd1,
    M_REG  = 3'd2,
    M_IND  = 3'd3,
    M_RIND = 3'd4,
    M_IDX  = 3'd5,
    M_BASE = 3'd6,
    M_STK  = 3'd7
  } mode_e;

  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_EA    = 3'd1,
    S_READ1 = 3'd2,
    S_READ2 = 3'd3,
    S_DONE  = 3'd4
  } state_e;
endpackage

// File: rtl/opf_ea_calc.sv
module opf_ea_calc
  import opf_pkg::*;
#(
  parameter int W   = 12,
  parameter int RIW = 3
) (
  input  mode_e          mode_i,
  input  logic [W-1:0]   field_i,
  input  logic [W-1:0]   reg_rdata_i,
  input  logic [W-1:0]   idx_i,
  input  logic [W-1:0]   base_i,
  input  logic [W-1:0]   sp_i,
  output logic [W-1:0]   ea_o,
  output logic [W-1:0]   val_o,
  output logic           needs_mem_o,
  output logic           chained_o
);
  always_comb begin
    ea_o        = field_i;
    val_o       = field_i;
    needs_mem_o = 1'b1;
    chained_o   = 1'b0;
    unique case (mode_i)
      M_IMM:  needs_mem_o = 1'b0;
      M_DIR:  ;
      M_REG: begin
        ea_o        = {{(W-RIW){1'b0}}, field_i[RIW-1:0]};
        val_o       = reg_rdata_i;
        needs_mem_o = 1'b0;
      end
      M_IND:  chained_o = 1'b1;          // ea_o is the pointer location here
      M_RIND: ea_o = reg_rdata_i;
      M_IDX:  ea_o = field_i + idx_i;    // wraps modulo 2**W
      M_BASE: ea_o = base_i + field_i;
      M_STK:  ea_o = sp_i;
      default: ;
    endcase
  end
endmodule

// File: rtl/opf_ctrl.sv
module opf_ctrl
  import opf_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   start_i,
  input  logic   needs_mem_i,
  input  logic   chained_i,
  output state_e state_o,
  output logic   done_o,
  output logic   busy_o
);
  state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE:  if (start_i) state_d = S_EA;
      S_EA:    state_d = needs_mem_i ? S_READ1 : S_DONE;
      S_READ1: state_d = chained_i ? S_READ2 : S_DONE;
      S_READ2: state_d = S_DONE;
      S_DONE:  state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= S_IDLE;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
  assign done_o  = (state_q == S_DONE);
  assign busy_o  = (state_q != S_IDLE);

  p_done_single_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_read2_follows_read1_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_READ2) |-> ($past(state_q) == S_READ1));
  p_start_while_busy_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> (state_q != S_EA));
endmodule

// File: rtl/opf_unit.sv
module opf_unit
  import opf_pkg::*;
#(
  parameter int W    = 12,
  parameter int NREG = 8,
  localparam int RIW = $clog2(NREG)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic [2:0]     mode_i,
  input  logic [W-1:0]   field_i,
  output logic [RIW-1:0] reg_sel_o,
  input  logic [W-1:0]   reg_rdata_i,
  input  logic [W-1:0]   idx_i,
  input  logic [W-1:0]   base_i,
  input  logic [W-1:0]   sp_i,
  output logic           mem_req_o,
  output logic [W-1:0]   mem_addr_o,
  input  logic [W-1:0]   mem_rdata_i,
  output logic [W-1:0]   operand_o,
  output logic [W-1:0]   ea_o,
  output logic           done_o,
  output logic           busy_o
);
  mode_e        mode_q;
  logic [W-1:0] field_q, ea_q, op_q;
  logic [W-1:0] calc_ea, calc_val;
  logic         needs_mem, chained;
  state_e       state;

  opf_ea_calc #(.W(W), .RIW(RIW)) u_ea (
    .mode_i      (mode_q),
    .field_i     (field_q),
    .reg_rdata_i (reg_rdata_i),
    .idx_i       (idx_i),
    .base_i      (base_i),
    .sp_i        (sp_i),
    .ea_o        (calc_ea),
    .val_o       (calc_val),
    .needs_mem_o (needs_mem),
    .chained_o   (chained)
  );

  opf_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .needs_mem_i (needs_mem),
    .chained_i   (chained),
    .state_o     (state),
    .done_o      (done_o),
    .busy_o      (busy_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= M_IMM;
      field_q <= '0;
      ea_q    <= '0;
      op_q    <= '0;
    end else begin
      unique case (state)
        S_IDLE: if (start_i) begin
          mode_q  <= mode_e'(mode_i);
          field_q <= field_i;
        end
        S_EA: begin
          ea_q <= calc_ea;
          if (!needs_mem) op_q <= calc_val;
        end
        S_READ1: begin
          if (chained) ea_q <= mem_rdata_i;  // pointer becomes the EA
          else         op_q <= mem_rdata_i;
        end
        S_READ2: op_q <= mem_rdata_i;
        default: ;
      endcase
    end
  end

  // Second indirect read is issued straight from the returning pointer.
  assign mem_req_o  = ((state == S_EA) && needs_mem) || ((state == S_READ1) && chained);
  assign mem_addr_o = (state == S_READ1) ? mem_rdata_i : calc_ea;
  assign reg_sel_o  = field_q[RIW-1:0];
  assign operand_o  = op_q;
  assign ea_o       = ea_q;

  p_no_read_imm_reg_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state == S_EA) && (mode_q == M_IMM || mode_q == M_REG)) |-> !mem_req_o);
  p_req_only_busy_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> busy_o);
  p_ind_ea_from_ptr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == S_READ2) |-> (ea_q == $past(mem_rdata_i)));
  p_field_held_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> $stable(field_q));
endmodule

// File: tb/opf_unit_tb.sv
`timescale 1ns/1ps
module opf_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  mode = '0;
  logic [11:0] field = '0;
  logic [2:0]  reg_sel;
  logic [11:0] reg_rdata;
  logic [11:0] idx = 12'h040, base = 12'h300, sp = 12'h7F0;
  logic        mem_req;
  logic [11:0] mem_addr;
  logic [11:0] mem_rdata = '0;
  logic [11:0] operand, ea;
  logic        done, busy;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  opf_unit u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mode_i(mode), .field_i(field),
    .reg_sel_o(reg_sel), .reg_rdata_i(reg_rdata), .idx_i(idx), .base_i(base), .sp_i(sp),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_rdata_i(mem_rdata),
    .operand_o(operand), .ea_o(ea), .done_o(done), .busy_o(busy)
  );

  function automatic logic [11:0] memf(input logic [11:0] a);
    return a * 12'd5 + 12'h031;
  endfunction
  function automatic logic [11:0] rf(input logic [2:0] i);
    return 12'h100 + 12'(i) * 12'h011;
  endfunction

  assign reg_rdata = rf(reg_sel);
  always_ff @(posedge clk) if (mem_req) mem_rdata <= memf(mem_addr);

  task automatic check(input bit ok, input string req, input string what,
                       input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic string req_of(input logic [2:0] m);
    case (m)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3: return "R5";
      3'd4: return "R6";
      3'd5: return "R7";
      3'd6: return "R8";
      default: return "R9";
    endcase
  endfunction

  // {mode, field}
  localparam logic [14:0] VEC [10] = '{
    {3'd0, 12'h123}, {3'd1, 12'h045}, {3'd2, 12'h005}, {3'd3, 12'h0A0},
    {3'd4, 12'h003}, {3'd5, 12'h010}, {3'd6, 12'h020}, {3'd7, 12'h555},
    {3'd5, 12'hFFF}, {3'd6, 12'hD10}
  };

  task automatic run(input logic [2:0] m, input logic [11:0] f);
    logic [11:0] e_ea, e_op;
    int e_lat, e_rd, cyc, rd;
    string rq;
    case (m)
      3'd0: begin e_ea = f; e_op = f; end
      3'd1: begin e_ea = f; e_op = memf(f); end
      3'd2: begin e_ea = {9'd0, f[2:0]}; e_op = rf(f[2:0]); end
      3'd3: begin e_ea = memf(f); e_op = memf(memf(f)); end
      3'd4: begin e_ea = rf(f[2:0]); e_op = memf(e_ea); end
      3'd5: begin e_ea = f + idx; e_op = memf(e_ea); end
      3'd6: begin e_ea = base + f; e_op = memf(e_ea); end
      default: begin e_ea = sp; e_op = memf(sp); end
    endcase
    e_lat = (m == 3'd0 || m == 3'd2) ? 2 : (m == 3'd3) ? 4 : 3;
    e_rd  = (m == 3'd0 || m == 3'd2) ? 0 : (m == 3'd3) ? 2 : 1;
    rq = req_of(m);
    @(negedge clk); start = 1'b1; mode = m; field = f;
    @(negedge clk); start = 1'b0;
    cyc = 1; rd = 0;
    while (!done && cyc < 20) begin
      if (mem_req) rd++;
      @(negedge clk); cyc++;
    end
    check(operand == e_op, rq, "operand", operand, e_op);
    check(ea == e_ea, rq, "ea", ea, e_ea);
    check(cyc == e_lat, "R10", "latency", 12'(cyc), 12'(e_lat));
    check(rd == e_rd, "R12", "read count", 12'(rd), 12'(e_rd));
    @(negedge clk);
    check(!done && !busy, "R10", "done width", {11'd0, done}, 12'd0);
  endtask

  initial begin
    int cnt = 0;
    forever begin
      @(posedge clk); cnt++;
      if (cnt > 100000) begin
        fails++; checks++;
        $display("FAIL watchdog expired actual=%0d expected=done", cnt);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!done && !busy && !mem_req, "R1", "ctrl after reset",
          {9'd0, done, busy, mem_req}, 12'd0);
    check(operand == 0 && ea == 0, "R1", "data after reset", operand | ea, 12'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 10; i++) run(VEC[i][14:12], VEC[i][11:0]);

    // R11: start pulses while busy, in READ1 and in DONE, are dropped
    @(negedge clk); start = 1'b1; mode = 3'd1; field = 12'h045;
    @(negedge clk); start = 1'b0;
    @(negedge clk); start = 1'b1; mode = 3'd0; field = 12'h777;
    @(negedge clk);
    check(done == 1'b1, "R11", "accepted op done", {11'd0, done}, 12'd1);
    check(operand == memf(12'h045), "R11", "operand kept", operand, memf(12'h045));
    start = 1'b0;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      check(!done && !busy, "R11", "no second fetch", {10'd0, done, busy}, 12'd0);
    end
    check(operand == memf(12'h045) && ea == 12'h045, "R11", "outputs held",
          operand, memf(12'h045));

    run(3'd3, 12'h0FF);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule